// File: doc/BRIEF.md
# Packet-Stream Memory Write Decoder

This block sits on the receive side of a packet-based host link. It takes a stream of 32-bit words, one packet at a time, and picks out the memory-write requests. For each one it reads the format and type fields of the first header word to learn how long the header is. It then takes the target address from the final one or two header words and writes the payload words into a small local register file, one word per payload word and one address step per word. Every other kind of packet is consumed and dropped, and the block never asks for a response packet.

The low byte of register 0 is also shown as two hexadecimal digits on a pair of seven-segment outputs, so a host write to offset 0 of the device window appears directly on the display. Writes only take effect while the memory-space-enable level from configuration space is high. A packet that starts while the level is low is swallowed whole.

Top module: `pkt_mwr_decoder`

## Requirements
- R1: After reset every register reads 0, `wr_stb` is 0, and both segment outputs show the digit 0 (7'h3F).
- R2: A word is accepted only in a cycle where `rx_valid` is high, and a packet begins only on an accepted word with `rx_sop` high. Words that arrive while idle without `rx_sop` change nothing.
- R3: The first header word carries the format in bits 30:29 and the type in bits 28:24. Format 2'b10 with type 0 is a write with a 3-word header, and its address is in word 2. Format 2'b11 with type 0 is a write with a 4-word header: word 2 holds the upper address half, which is ignored, and word 3 holds the lower half.
- R4: Payload starts on the word after the last header word. The first payload word goes to word index address[15:2], and each further word goes to the next index. Only indices 0 to NREGS-1 are written; any index at or above NREGS is dropped, and address bits above bit 15 have no effect.
- R5: Bits 9:0 of the first header word give the payload length in words, with 0 meaning 1024. Words beyond that length are dropped.
- R6: `mem_en` is sampled on the start word. If it is low, the whole packet causes no write.
- R7: One cycle after an accepted payload word that is in range, `wr_stb` shows the written index as a single set bit, and the register shows the new value in that same cycle. In all other cycles `wr_stb` is 0 and the registers hold their values.
- R8: A packet with any other format or a nonzero type is skipped up to its end and writes nothing.
- R9: An accepted word with `rx_eop` returns the parser to idle after that word is processed. A payload word carrying `rx_eop` is still written. A start word arriving in the middle of a packet abandons the old packet and is decoded as a new header.
- R10: `seg_lo` shows bits 3:0 and `seg_hi` shows bits 7:4 of register 0 as hexadecimal digits. The segments are active high, with bit 0 driving segment a up to bit 6 driving segment g.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive word valid |
| rx_sop | input | 1 | First word of a packet |
| rx_eop | input | 1 | Last word of a packet |
| rx_data | input | 32 | Receive data word |
| mem_en | input | 1 | Memory space enable from configuration space |
| wr_stb | output | NREGS | One-hot strobe for the register written in the previous cycle |
| regs_flat | output | NREGS*32 | All register contents, register i at bits 32*i+31:32*i |
| seg_lo | output | 7 | Segment pattern for the low hex digit of register 0 |
| seg_hi | output | 7 | Segment pattern for the high hex digit of register 0 |

## Verification
A payload write and the end of a packet can fall on the same word. The register must then be updated even though the parser leaves the packet in that cycle. The bench provokes this by putting `rx_eop` on the final payload word of every write packet. It judges the result by comparing all registers and the total count of strobe pulses against a packet-level model. A second collision is a start word arriving in the middle of a payload. The bench sends a truncated burst with no end marker, followed directly by a new packet, and checks that the new header word is never written as data.

// File: rtl/mwd_pkg.sv
package mwd_pkg;

    localparam int DW        = 32;
    localparam int LEN_BITS  = 10;
    localparam int SEG_W     = 7;
    localparam int MAX_WORDS = 1 << LEN_BITS;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_SKIP
    } pstate_e;

    typedef struct packed {
        logic is_write;
        logic hdr4;
    } hdr_info_t;

    // Classify the first header word: format in 30:29, type in 28:24.
    function automatic hdr_info_t classify(input logic [DW-1:0] w);
        hdr_info_t r;
        r.is_write = (w[30:29] inside {2'b10, 2'b11}) && (w[28:24] == 5'd0);
        r.hdr4     = w[29];
        return r;
    endfunction

    // Payload length in words; a zero field stands for the maximum.
    function automatic logic [LEN_BITS:0] payload_len(input logic [DW-1:0] w);
        logic [LEN_BITS:0] n;
        n = (w[LEN_BITS-1:0] == '0) ? (LEN_BITS+1)'(MAX_WORDS)
                                    : {1'b0, w[LEN_BITS-1:0]};
        return n;
    endfunction

    // Hex nibble to active-high segments, bit 0 = a ... bit 6 = g.
    function automatic logic [SEG_W-1:0] hex_seg(input logic [3:0] v);
        logic [SEG_W-1:0] s;
        case (v)
            4'h0: s = 7'h3F;
            4'h1: s = 7'h06;
            4'h2: s = 7'h5B;
            4'h3: s = 7'h4F;
            4'h4: s = 7'h66;
            4'h5: s = 7'h6D;
            4'h6: s = 7'h7D;
            4'h7: s = 7'h07;
            4'h8: s = 7'h7F;
            4'h9: s = 7'h6F;
            4'hA: s = 7'h77;
            4'hB: s = 7'h7C;
            4'hC: s = 7'h39;
            4'hD: s = 7'h5E;
            4'hE: s = 7'h79;
            default: s = 7'h71;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mwd_parser.sv
module mwd_parser
    import mwd_pkg::*;
#(
    parameter int NREGS    = 16,
    parameter int WIN_BITS = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rx_valid,
    input  logic                     rx_sop,
    input  logic                     rx_eop,
    input  logic [DW-1:0]            rx_data,
    input  logic                     mem_en,
    output logic                     wr_en,
    output logic [$clog2(NREGS)-1:0] wr_idx,
    output logic [DW-1:0]            wr_data
);
    localparam int IDXW = $clog2(NREGS);
    // word address inside the window plus one guard bit against wrap
    localparam int WA   = WIN_BITS - 1;

    pstate_e             state_q, state_d;
    logic                hdr4_q, hdr4_d;
    logic [1:0]          wcnt_q, wcnt_d;
    logic [WA-1:0]       addr_q, addr_d;
    logic [LEN_BITS:0]   remain_q, remain_d;
    hdr_info_t           info;
    logic                in_range;

    assign info     = classify(rx_data);
    assign in_range = (addr_q[WA-1:IDXW] == '0);

    always_comb begin
        state_d  = state_q;
        hdr4_d   = hdr4_q;
        wcnt_d   = wcnt_q;
        addr_d   = addr_q;
        remain_d = remain_q;
        wr_en    = 1'b0;
        wr_idx   = addr_q[IDXW-1:0];
        wr_data  = rx_data;
        if (rx_valid) begin
            if (rx_sop) begin
                hdr4_d   = info.hdr4;
                wcnt_d   = 2'd1;
                remain_d = payload_len(rx_data);
                state_d  = (info.is_write && mem_en) ? ST_HDR : ST_SKIP;
            end else begin
                case (state_q)
                    ST_HDR: begin
                        if (wcnt_q == (hdr4_q ? 2'd3 : 2'd2)) begin
                            addr_d  = {1'b0, rx_data[WIN_BITS-1:2]};
                            state_d = ST_DATA;
                        end
                        wcnt_d = wcnt_q + 2'd1;
                    end
                    ST_DATA: begin
                        wr_en    = in_range;
                        addr_d   = addr_q + 1'b1;
                        remain_d = remain_q - 1'b1;
                        if (remain_q == (LEN_BITS+1)'(1)) state_d = ST_SKIP;
                    end
                    default: ;
                endcase
            end
            if (rx_eop) state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            hdr4_q   <= 1'b0;
            wcnt_q   <= 2'd0;
            addr_q   <= '0;
            remain_q <= '0;
        end else begin
            state_q  <= state_d;
            hdr4_q   <= hdr4_d;
            wcnt_q   <= wcnt_d;
            addr_q   <= addr_d;
            remain_q <= remain_d;
        end
    end

    p_eop_to_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_eop) |=> (state_q == ST_IDLE));

    p_idle_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !wr_en);

    p_remain_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA) |-> (remain_q != '0));

    p_disabled_skips_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_sop && !mem_en) |=> (state_q != ST_HDR));

    p_bad_type_skips_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_sop && !rx_eop && (rx_data[28:24] != 5'd0)) |=> (state_q == ST_SKIP));

endmodule

// File: rtl/mwd_regfile.sv
module mwd_regfile
    import mwd_pkg::*;
#(
    parameter int NREGS = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [$clog2(NREGS)-1:0] wr_idx,
    input  logic [DW-1:0]            wr_data,
    output logic [NREGS*DW-1:0]      regs_flat,
    output logic [NREGS-1:0]         wr_stb
);
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_flat[g*DW +: DW] <= '0;
            end else if (wr_en && (wr_idx == g)) begin
                regs_flat[g*DW +: DW] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        wr_stb <= '0;
        else if (wr_en) wr_stb <= NREGS'(1) << wr_idx;
        else            wr_stb <= '0;
    end

    p_stb_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_stb));

    p_hold_without_stb_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_stb == '0) |-> $stable(regs_flat));

endmodule

// File: rtl/mwd_seg.sv
module mwd_seg
    import mwd_pkg::*;
#(
    parameter int DIGITS = 2
) (
    input  logic [DIGITS*4-1:0]     value,
    output logic [DIGITS*SEG_W-1:0] segs
);
    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        assign segs[d*SEG_W +: SEG_W] = hex_seg(value[d*4 +: 4]);
    end
endmodule

// File: rtl/pkt_mwr_decoder.sv
module pkt_mwr_decoder
    import mwd_pkg::*;
#(
    parameter int NREGS    = 16,
    parameter int WIN_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_valid,
    input  logic                 rx_sop,
    input  logic                 rx_eop,
    input  logic [31:0]          rx_data,
    input  logic                 mem_en,
    output logic [NREGS-1:0]     wr_stb,
    output logic [NREGS*32-1:0]  regs_flat,
    output logic [6:0]           seg_lo,
    output logic [6:0]           seg_hi
);
    localparam int IDXW = $clog2(NREGS);

    logic              wr_en;
    logic [IDXW-1:0]   wr_idx;
    logic [DW-1:0]     wr_data;
    logic [2*SEG_W-1:0] seg_all;

    mwd_parser #(.NREGS(NREGS), .WIN_BITS(WIN_BITS)) u_parser (
        .clk(clk), .rst(rst),
        .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop),
        .rx_data(rx_data), .mem_en(mem_en),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    mwd_regfile #(.NREGS(NREGS)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .regs_flat(regs_flat), .wr_stb(wr_stb)
    );

    mwd_seg #(.DIGITS(2)) u_seg (
        .value(regs_flat[7:0]),
        .segs(seg_all)
    );

    assign seg_lo = seg_all[SEG_W-1:0];
    assign seg_hi = seg_all[2*SEG_W-1:SEG_W];

    p_seg_follows_reg0_r10: assert property (@(posedge clk) disable iff (rst)
        $stable(regs_flat[7:0]) |-> ($stable(seg_lo) && $stable(seg_hi)));

endmodule

// File: tb/test_pkt_mwr_decoder.sv
module test_pkt_mwr_decoder;
    localparam int NREGS = 16;

    logic clk = 1'b0;
    logic rst;
    logic rx_valid, rx_sop, rx_eop, mem_en;
    logic [31:0] rx_data;
    logic [NREGS-1:0]    wr_stb;
    logic [NREGS*32-1:0] regs_flat;
    logic [6:0] seg_lo, seg_hi;

    always #10 clk = ~clk;

    pkt_mwr_decoder #(.NREGS(NREGS), .WIN_BITS(16)) i_pkt_mwr_decoder (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sop(rx_sop),
        .rx_eop(rx_eop), .rx_data(rx_data), .mem_en(mem_en),
        .wr_stb(wr_stb), .regs_flat(regs_flat), .seg_lo(seg_lo), .seg_hi(seg_hi)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] exp_regs [NREGS];
    logic [31:0] pay [0:15];
    int stb_seen = 0;
    int stb_exp = 0;

    always @(negedge clk) if (!rst) stb_seen += $countones(wr_stb);

    function automatic logic [6:0] ref_seg(input logic [3:0] v);
        logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                               7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
        return t[v];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic put_word(input logic [31:0] d, input bit sop, input bit eop);
        @(negedge clk);
        rx_valid = 1'b1; rx_sop = sop; rx_eop = eop; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_data = $urandom;
    endtask

    // Build, send and model one packet. ntot = words actually sent.
    task automatic send_pkt(input logic [1:0] fmt, input logic [4:0] typ,
                            input logic [31:0] hi, input logic [31:0] lo,
                            input logic [9:0] len, input int ntot,
                            input bit en, input bit with_eop);
        int hlen;
        int npay;
        int lenw;
        logic [31:0] w;
        hlen = fmt[0] ? 4 : 3;
        mem_en = en;
        for (int i = 0; i < 16; i++) pay[i] = $urandom;
        for (int i = 0; i < ntot; i++) begin
            if (i == 0)                 w = {1'b0, fmt, typ, 14'd0, len};
            else if (i == 1)            w = $urandom;
            else if (i == 2 && hlen==4) w = hi;
            else if (i == hlen - 1)     w = lo;
            else                        w = pay[i - hlen];
            put_word(w, i == 0, with_eop && (i == ntot - 1));
        end
        // packet-level reference
        if (en && fmt[1] && typ == 5'd0) begin
            npay = (ntot > hlen) ? ntot - hlen : 0;
            lenw = (len == 10'd0) ? 1024 : int'(len);
            if (npay > lenw) npay = lenw;
            for (int k = 0; k < npay; k++) begin
                int idx;
                idx = int'(lo[15:2]) + k;
                if (idx < NREGS) begin
                    exp_regs[idx] = pay[k];
                    stb_exp++;
                end
            end
        end
    endtask

    task automatic check_all(input string req);
        @(negedge clk);
        for (int i = 0; i < NREGS; i++)
            chk(regs_flat[i*32 +: 32] === exp_regs[i], req, $sformatf("reg%0d", i),
                64'(regs_flat[i*32 +: 32]), 64'(exp_regs[i]));
        chk(seg_lo === ref_seg(exp_regs[0][3:0]), "R10", "seg_lo", 64'(seg_lo),
            64'(ref_seg(exp_regs[0][3:0])));
        chk(seg_hi === ref_seg(exp_regs[0][7:4]), "R10", "seg_hi", 64'(seg_hi),
            64'(ref_seg(exp_regs[0][7:4])));
        chk(stb_seen == stb_exp, "R7", "strobe pulses", 64'(stb_seen), 64'(stb_exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; rx_valid = 0; rx_sop = 0; rx_eop = 0; rx_data = 0; mem_en = 1;
        for (int i = 0; i < NREGS; i++) exp_regs[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(regs_flat === '0, "R1", "regs", 64'(regs_flat[63:0]), 64'd0);
        chk(wr_stb === '0, "R1", "wr_stb", 64'(wr_stb), 64'd0);
        chk(seg_lo === 7'h3F && seg_hi === 7'h3F, "R1", "segs",
            {50'd0, seg_hi, seg_lo}, {50'd0, 7'h3F, 7'h3F});

        // R3 3-word header write to register 0, R10 display
        send_pkt(2'b10, 5'd0, 32'd0, 32'h0000_0000, 10'd1, 4, 1, 1);
        check_all("R3");
        // R3 4-word header, upper half ignored
        send_pkt(2'b11, 5'd0, 32'hDEAD_BEEF, 32'h0000_0008, 10'd2, 6, 1, 1);
        check_all("R3");
        // R6 enable off
        send_pkt(2'b10, 5'd0, 32'd0, 32'h0000_0010, 10'd1, 4, 0, 1);
        check_all("R6");
        // R8 format without data
        send_pkt(2'b00, 5'd0, 32'd0, 32'h0000_0014, 10'd2, 5, 1, 1);
        check_all("R8");
        // R8 nonzero type
        send_pkt(2'b10, 5'b00100, 32'd0, 32'h0000_0018, 10'd1, 4, 1, 1);
        check_all("R8");
        // R4 burst running past the last register
        send_pkt(2'b10, 5'd0, 32'd0, 32'h0000_0034, 10'd5, 8, 1, 1);
        check_all("R4");
        // R5 length shorter than words sent
        send_pkt(2'b10, 5'd0, 32'd0, 32'h0000_0024, 10'd2, 7, 1, 1);
        check_all("R5");
        // R5 zero length means 1024, cut by end marker
        send_pkt(2'b11, 5'd0, 32'd1, 32'h0000_0020, 10'd0, 7, 1, 1);
        check_all("R5");
        // R4 address bits above the window ignored; out-of-range index dropped
        send_pkt(2'b10, 5'd0, 32'd0, 32'h0001_0004, 10'd1, 4, 1, 1);
        check_all("R4");
        send_pkt(2'b10, 5'd0, 32'd0, 32'h0000_0100, 10'd1, 4, 1, 1);
        check_all("R4");
        // R9 end marker inside the header
        send_pkt(2'b10, 5'd0, 32'd0, 32'h0000_0000, 10'd1, 2, 1, 1);
        check_all("R9");
        // R9 new start in the middle of a payload
        send_pkt(2'b10, 5'd0, 32'd0, 32'h0000_0004, 10'd4, 4, 1, 0);
        send_pkt(2'b10, 5'd0, 32'd0, 32'h0000_0000, 10'd1, 4, 1, 1);
        check_all("R9");
        // R2 stray words while idle
        put_word(32'h4000_0001, 0, 0);
        put_word(32'h0000_0000, 0, 0);
        put_word(32'h0000_0000, 0, 0);
        put_word(32'h1234_5678, 0, 1);
        check_all("R2");

        // random mix
        for (int n = 0; n < 60; n++) begin
            logic [1:0] fmt;
            logic [4:0] typ;
            logic [9:0] len;
            logic [31:0] lo;
            int hl, nt;
            fmt = ($urandom % 4 == 0) ? 2'($urandom) : {1'b1, 1'($urandom)};
            typ = ($urandom % 6 == 0) ? 5'($urandom) : 5'd0;
            len = 10'(1 + $urandom % 6);
            lo  = {($urandom % 8 == 0) ? 16'($urandom) : 16'd0, 8'd0,
                   6'($urandom % 20), 2'($urandom)};
            hl  = fmt[0] ? 4 : 3;
            nt  = hl + int'($urandom % (int'(len) + 3));
            if ($urandom % 8 == 0) nt = 1 + int'($urandom % hl);
            send_pkt(fmt, typ, $urandom, lo, len, nt, ($urandom % 10) != 0, 1);
            check_all("R4");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule